// File: doc/BRIEF.md
# Compressed Instruction Pair Expander

This front-end stage sits between instruction fetch and decode. Each fetched 32-bit word arrives on a valid/ready input stream. When bit 31 of the word is clear, the word already is a full-width instruction and goes out unchanged as a single issue. When bit 31 is set, the word carries two 16-bit compressed instructions. Each half is rewritten into the full 32-bit encoding, and the two results go out one after the other on a valid/ready output stream, the upper half first.

The decode stage reports on `redirect` whether the instruction it is accepting changes control flow or privilege mode. If that happens on the upper half of a pair, the lower half is discarded. A `phase` output is high while the lower half of a pair is the instruction on offer. Once the last instruction taken from a word has been accepted without a redirect, `pc_adv` pulses for one cycle to ask for the program counter to step. `flush` drops whatever the stage holds.

Back-pressure rules: the stage holds one word at a time, and `in_ready` stays low while any instruction from that word is still on offer. An offered instruction keeps `out_valid` high and `out_insn` unchanged until `out_ready` takes it. `redirect` is only looked at in the cycle of an output handshake.

Top module: `cpair_expander`

## Requirements
- R1: A word with bit 31 clear is issued once, unchanged, with `phase` low.
- R2: A word with bit 31 set issues two instructions: the expansion of bits 31:16 first, then the expansion of bits 15:0.
- R3: In a compressed half, bits 14:11 give the destination register and bits 10:8 a code that maps as 0→0, 1→1, 2→2, 3→16, 4→18, 5→19, 6→24, 7→13. The expansion has bit 31 set, the destination in bits 30:27 and the mapped opcode in bits 26:22.
- R4: Code 6 ORs half bits 7:0, sign-extended to 23 bits, into bits 22:0. No register operand is used.
- R5: Code 7 places half bits 6:3 in bits 17:14 and half bits 2:0, sign-extended to 13 bits, in bits 12:0. Bit 18 is clear.
- R6: The other codes with half bit 7 set place half bits 6:3 in bits 17:14, set bit 18, and place half bits 2:0, sign-extended to 14 bits, in bits 13:0.
- R7: Codes 4 and 5 with half bit 7 clear place register 13 in bits 17:14, set bit 18, and place half bits 6:0, sign-extended to 14 bits, in bits 13:0.
- R8: Codes 0 to 3 with half bit 7 clear place half bits 6:0, sign-extended to 18 bits, in bits 17:0. Bits 21:18 are zero.
- R9: `phase` is high exactly while the lower half of a pair is on offer. It is low after reset and for full-width words.
- R10: Accepting the upper half with `redirect` high discards the lower half, so the stage is empty in the next cycle.
- R11: `pc_adv` pulses high for one cycle, in the cycle after the last instruction of a word is accepted with `redirect` low. It does not pulse when that instruction is accepted with `redirect` high.
- R12: `flush` holds `in_ready` low. The stage is empty with `phase` low in the next cycle, and no `pc_adv` follows.
- R13: While an instruction is on offer and not accepted, `out_valid` stays high, `out_insn` is stable and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetched word is present |
| in_ready | output | 1 | Stage can take a word |
| in_word | input | 32 | Fetched word |
| out_valid | output | 1 | Instruction on offer |
| out_ready | input | 1 | Decode takes the instruction |
| out_insn | output | 32 | Full-width instruction |
| redirect | input | 1 | The accepted instruction jumps or changes mode |
| flush | input | 1 | Discard held word and pending half |
| phase | output | 1 | Lower half of a pair is on offer |
| pc_adv | output | 1 | One-cycle program-counter step request |

## Verification
A wrong phase register shows up at the ports within one handshake. Either the lower expansion appears where the upper one belongs, or a pair ends after one issue, or the stage waits for a third. Any of these also moves or removes the `pc_adv` pulse in the following cycle. A stale busy state after a redirect or flush shows up in the next cycle as `out_valid` still high or `in_ready` still low. A wrong field in the expander corrupts `out_insn` in the very cycle the half is offered.

// File: rtl/cpair_pkg.sv
package cpair_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = WORD_W / 2;
  localparam int unsigned OP_W   = 5;
  localparam int unsigned REG_W  = 4;
  localparam int unsigned N_HALF = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [OP_W-1:0]   op_t;

  localparam op_t OP_SUB = 5'd0;
  localparam op_t OP_AND = 5'd1;
  localparam op_t OP_ADD = 5'd2;
  localparam op_t OP_MOV = 5'd13;
  localparam op_t OP_CMP = 5'd16;
  localparam op_t OP_LW  = 5'd18;
  localparam op_t OP_SW  = 5'd19;
  localparam op_t OP_LDI = 5'd24;

  function automatic op_t map_code(input logic [2:0] code);
    case (code)
      3'd0:    return OP_SUB;
      3'd1:    return OP_AND;
      3'd2:    return OP_ADD;
      3'd3:    return OP_CMP;
      3'd4:    return OP_LW;
      3'd5:    return OP_SW;
      3'd6:    return OP_LDI;
      default: return OP_MOV;
    endcase
  endfunction
endpackage

// File: rtl/cpair_half_expand.sv
module cpair_half_expand
  import cpair_pkg::*;
#(
  parameter logic [REG_W-1:0] BASE_REG = 4'd13
) (
  input  half_t half_i,
  output word_t full_o
);
  logic [2:0]       code;
  logic [REG_W-1:0] dst;
  logic [REG_W-1:0] breg;
  logic             rflag;
  word_t            imm;
  word_t            sx3, sx7, sx8;

  always_comb begin
    code  = half_i[10:8];
    dst   = half_i[14:11];
    sx3   = {{(WORD_W-3){half_i[2]}}, half_i[2:0]};
    sx7   = {{(WORD_W-7){half_i[6]}}, half_i[6:0]};
    sx8   = {{(WORD_W-8){half_i[7]}}, half_i[7:0]};
    breg  = '0;
    rflag = 1'b0;
    imm   = '0;
    if (code == 3'd6) begin
      imm = {9'b0, sx8[22:0]};
    end else if (code == 3'd7) begin
      breg = half_i[6:3];
      imm  = {19'b0, sx3[12:0]};
    end else if (half_i[7]) begin
      breg  = half_i[6:3];
      rflag = 1'b1;
      imm   = {18'b0, sx3[13:0]};
    end else if (code == 3'd4 || code == 3'd5) begin
      breg  = BASE_REG;
      rflag = 1'b1;
      imm   = {18'b0, sx7[13:0]};
    end else begin
      imm = {14'b0, sx7[17:0]};
    end
    full_o = {1'b1, dst, map_code(code), 3'b000, rflag, breg, 14'b0} | imm;
  end
endmodule

// File: rtl/cpair_issue_ctrl.sv
module cpair_issue_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_compr,
  input  logic out_ready,
  input  logic redirect,
  input  logic flush,
  output logic in_ready,
  output logic load_en,
  output logic busy,
  output logic compr,
  output logic phase,
  output logic pc_adv
);
  logic busy_q, compr_q, phase_q, adv_q;
  logic fire, last;

  assign in_ready = !busy_q && !flush;
  assign load_en  = in_valid && in_ready;
  assign fire     = busy_q && out_ready && !flush;
  assign last     = !compr_q || phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      compr_q <= 1'b0;
      phase_q <= 1'b0;
      adv_q   <= 1'b0;
    end else begin
      adv_q <= fire && last && !redirect;
      if (flush) begin
        busy_q  <= 1'b0;
        phase_q <= 1'b0;
      end else if (load_en) begin
        busy_q  <= 1'b1;
        compr_q <= in_compr;
        phase_q <= 1'b0;
      end else if (fire) begin
        if (last || redirect) begin
          busy_q  <= 1'b0;
          phase_q <= 1'b0;
        end else begin
          phase_q <= 1'b1;
        end
      end
    end
  end

  assign busy   = busy_q;
  assign compr  = compr_q;
  assign phase  = phase_q;
  assign pc_adv = adv_q;
endmodule

// File: rtl/cpair_expander.sv
module cpair_expander
  import cpair_pkg::*;
#(
  parameter logic [REG_W-1:0] STACK_REG = 4'd13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_insn,
  input  logic        redirect,
  input  logic        flush,
  output logic        phase,
  output logic        pc_adv
);
  word_t word_q;
  word_t exp_w [N_HALF];
  logic  load_en, busy, compr;

  cpair_issue_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_compr (in_word[WORD_W-1]),
    .out_ready(out_ready),
    .redirect (redirect),
    .flush    (flush),
    .in_ready (in_ready),
    .load_en  (load_en),
    .busy     (busy),
    .compr    (compr),
    .phase    (phase),
    .pc_adv   (pc_adv)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= '0;
    else if (load_en) word_q <= in_word;
  end

  for (genvar g = 0; g < N_HALF; g++) begin : g_half
    cpair_half_expand #(.BASE_REG(STACK_REG)) u_exp (
      .half_i(word_q[g*HALF_W +: HALF_W]),
      .full_o(exp_w[g])
    );
  end

  assign out_valid = busy;
  assign out_insn  = !compr ? word_q : (phase ? exp_w[0] : exp_w[1]);
endmodule

// File: rtl/cpair_expander_chk.sv
module cpair_expander_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_insn,
  input logic        redirect,
  input logic        flush,
  input logic        phase,
  input logic        pc_adv
);
  assert_hold_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !flush |=> out_valid && $stable(out_insn));
  assert_busy_blocks_input_R13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  assert_phase_needs_offer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    phase |-> out_valid && out_insn[31]);
  assert_flush_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid && !phase && !pc_adv);
  assert_adv_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pc_adv |=> !pc_adv);
  assert_adv_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pc_adv |-> $past(out_valid && out_ready && !redirect && !flush));
  assert_redirect_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && redirect && !flush |=> !out_valid && !pc_adv);
endmodule

bind cpair_expander cpair_expander_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_insn(out_insn), .redirect(redirect),
  .flush(flush), .phase(phase), .pc_adv(pc_adv)
);

// File: tb/cpair_expander_tb.sv
module cpair_expander_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_insn;
  logic        redirect = 1'b0;
  logic        flush = 1'b0;
  logic        phase;
  logic        pc_adv;
  int          n_chk = 0;
  int          n_err = 0;

  always #2 clk = ~clk;

  cpair_expander u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_insn(out_insn), .redirect(redirect), .flush(flush),
    .phase(phase), .pc_adv(pc_adv)
  );

  // {two issues, word, first expected, second expected}
  localparam int NV = 6;
  localparam logic [96:0] TBL [NV] = '{
    {1'b1, 32'h9205089F, 32'h90800005, 32'h8804FFFF},  // R8 ADD imm, R6 SUB reg
    {1'b1, 32'h9EF02F23, 32'h9E7FFFF0, 32'hAB410003},  // R4 LDI, R5 MOV
    {1'b1, 32'h8C7C1340, 32'h8C877FFC, 32'h9403FFC0},  // R7 LW stack, R8 CMP neg
    {1'b1, 32'h9D92093F, 32'h9CC48002, 32'h8840003F},  // R6 SW reg, R8 AND
    {1'b0, 32'h12345678, 32'h12345678, 32'h00000000},  // R1
    {1'b0, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h00000000}   // R1
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2 R3 R6 R8";
      1: return "R2 R3 R4 R5";
      2: return "R2 R3 R7 R8";
      3: return "R2 R3 R6 R8";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset phase", {31'b0, phase}, 32'd0);
    chk("R13 reset out_valid", {31'b0, out_valid}, 32'd0);
    chk("R11 reset pc_adv", {31'b0, pc_adv}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 idle in_ready", {31'b0, in_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      send(TBL[i][95:64]);
      chk({tag_of(i), " first valid"}, {31'b0, out_valid}, 32'd1);
      chk({tag_of(i), " first insn"}, out_insn, TBL[i][63:32]);
      chk("R9 phase on first", {31'b0, phase}, 32'd0);
      out_ready = 1'b1;
      @(negedge clk);
      if (TBL[i][96]) begin
        chk("R9 phase on second", {31'b0, phase}, 32'd1);
        chk({tag_of(i), " second insn"}, out_insn, TBL[i][31:0]);
        chk("R11 no adv mid pair", {31'b0, pc_adv}, 32'd0);
        @(negedge clk);
      end
      out_ready = 1'b0;
      chk("R2 empty after word", {31'b0, out_valid}, 32'd0);
      chk("R11 adv pulse", {31'b0, pc_adv}, 32'd1);
      chk("R9 phase cleared", {31'b0, phase}, 32'd0);
      @(negedge clk);
      chk("R11 adv one cycle", {31'b0, pc_adv}, 32'd0);
    end

    // R10: redirect on the upper half drops the lower half
    send(32'h9205089F);
    out_ready = 1'b1;
    redirect  = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    redirect  = 1'b0;
    chk("R10 lower dropped", {31'b0, out_valid}, 32'd0);
    chk("R10 phase low", {31'b0, phase}, 32'd0);
    chk("R11 no adv on redirect", {31'b0, pc_adv}, 32'd0);
    chk("R10 ready again", {31'b0, in_ready}, 32'd1);
    @(negedge clk);
    chk("R11 still no adv", {31'b0, pc_adv}, 32'd0);

    // R13: back-pressure holds the offer and blocks input
    send(32'h9EF02F23);
    in_valid = 1'b1;
    in_word  = 32'h12345678;
    for (int k = 0; k < 3; k++) begin
      chk("R13 held valid", {31'b0, out_valid}, 32'd1);
      chk("R13 held insn", out_insn, 32'h9E7FFFF0);
      chk("R13 input blocked", {31'b0, in_ready}, 32'd0);
      @(negedge clk);
    end
    in_valid  = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R13 second after stall", out_insn, 32'hAB410003);
    @(negedge clk);
    out_ready = 1'b0;
    chk("R13 blocked word not taken", {31'b0, out_valid}, 32'd0);
    chk("R11 adv after stall", {31'b0, pc_adv}, 32'd1);

    // R12: flush while the lower half is pending
    send(32'h8C7C1340);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R9 pending phase", {31'b0, phase}, 32'd1);
    flush = 1'b1;
    #0;
    chk("R12 in_ready low in flush", {31'b0, in_ready}, 32'd0);
    @(negedge clk);
    flush = 1'b0;
    chk("R12 flushed valid", {31'b0, out_valid}, 32'd0);
    chk("R12 flushed phase", {31'b0, phase}, 32'd0);
    chk("R12 no adv", {31'b0, pc_adv}, 32'd0);

    // R11: redirect on a full-width word suppresses the advance
    send(32'h12345678);
    out_ready = 1'b1;
    redirect  = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    redirect  = 1'b0;
    chk("R11 full word redirect", {31'b0, pc_adv}, 32'd0);
    chk("R1 single issue", {31'b0, out_valid}, 32'd0);

    // R10/R11: redirect on the lower half
    send(32'h9D92093F);
    out_ready = 1'b1;
    @(negedge clk);
    redirect = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    redirect  = 1'b0;
    chk("R11 lower redirect no adv", {31'b0, pc_adv}, 32'd0);
    chk("R10 empty after lower", {31'b0, out_valid}, 32'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule